// File: doc/BRIEF.md
# Event Stream Integrity Checker

This block watches a stream of 32-bit words that carries one readout event at a time and checks every event against its expected framing. A good event opens with a start control word and closes with an end control word. In between are two frames per front-end board, each made of a header, a fixed number of data words and a checksum word. The expected number of data words per frame and the number of boards are configuration inputs. They are sampled live and are changed only while no event is open.

The checker does not give a plain pass/fail answer. It works out which kind of word went missing: start control, header, data, checksum or end control. It uses only the marker bits of each word and the expected frame layout to do this. Each kind has its own saturating counter, and a sixth counter tallies parity errors in data words. When an event is closed, the block pulses a done strobe for one cycle and presents a 7-bit status word for that event. A checksum mismatch shows only in this status word.

Top module: `evchk_top`

## Requirements
- R1: Words are classified by their top bits. Bit 31 = 0 is a data or checksum word. Bits 31:30 = 10 is a frame header. Bits 31:29 = 110 is a start control word. Bits 31:29 = 111 is an end control word.
- R2: An event is closed by an end control word. The cycle after the clock edge that accepts that word, `ev_done` is high for exactly one cycle and `ev_status` holds the event's flags. The flags are: bit 0 missing start, bit 1 missing header, bit 2 missing data, bit 3 missing checksum, bit 4 missing end, bit 5 parity error, bit 6 checksum mismatch. A complete, correct event reports status 0 and changes no counter.
- R3: A data word passes parity only when the number of ones in bits 30:0 is even. Each data word that fails adds 1 to `cnt_parity` and sets status bit 5.
- R4: Once a frame has received the configured number of data words, the next word with bit 31 clear is its checksum. That word's bits 30:0 are compared with the XOR of bits 30:0 of the frame's data words. A mismatch sets status bit 6 and changes no counter.
- R5: A header that arrives while a frame still expects data ends that frame. The shortfall in data words is added to `cnt_nodata`, and `cnt_nocks` gains 1.
- R6: A header that arrives where a checksum is expected adds 1 to `cnt_nocks` and nothing to `cnt_nodata`.
- R7: A data word that arrives where a header is expected adds 1 to `cnt_nohdr`. That word then counts as the first data word of a new frame.
- R8: When an event closes after fewer frames than twice `cfg_boards`, the number of frames never started is added to `cnt_nohdr`.
- R9: A header, data word or end control word that arrives while no event is open adds 1 to `cnt_nostart`. An event is then opened and the word is processed inside it.
- R10: A start control word that arrives while an event is open adds 1 to `cnt_noend`. It closes the open event with a done pulse and status bit 4 set, and opens a new event.
- R11: Every counter stops at its all-ones value and stays there.
- R12: While `clr_cnt` is high at a clock edge, all six counters become 0 at that edge.
- R13: After reset, all counters are 0, `ev_done` is low and no event is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_cnt | input | 1 | Synchronous clear of all counters |
| in_valid | input | 1 | Qualifies `in_word` for this cycle |
| in_word | input | 32 | Stream word |
| cfg_samples | input | SAMP_W | Expected data words per frame (1 or more) |
| cfg_boards | input | BRD_W | Number of boards; two frames per board |
| ev_done | output | 1 | One-cycle pulse when an event closes |
| ev_status | output | 7 | Flags of the last closed event |
| cnt_nostart | output | CNT_W | Missing start control words |
| cnt_nohdr | output | CNT_W | Missing headers |
| cnt_nodata | output | CNT_W | Missing data words |
| cnt_nocks | output | CNT_W | Missing checksum words |
| cnt_noend | output | CNT_W | Missing end control words |
| cnt_parity | output | CNT_W | Data words with a parity error |

## Verification
The bench drives a clean event, then events each of which has a single defect in a chosen place. The defects are a flipped parity bit, a corrupted checksum, a data run cut short by the next header, a dropped checksum, a dropped header, frames missing before the end word, a dropped start word and a dropped end word. Each defect must raise exactly one counter and status bit, or the documented pair. This separates a header loss from a checksum loss, and a checksum loss from a data shortfall, although both losses come from the same kind of stream disruption. A clean event after the missing-end case shows that a status is scoped to its own event. Short events repeated with a narrow counter width exercise saturation and the clear input.

// File: rtl/evchk_pkg.sv
package evchk_pkg;
  typedef enum logic [1:0] {W_DATA, W_HDR, W_START, W_END} wkind_e;
  typedef enum logic [1:0] {P_IDLE, P_HDR, P_DATA, P_CKS} pstate_e;

  localparam int NCNT = 6;
  localparam int ST_W = 7;
  // counter slots, also the low status bit positions
  localparam int C_START = 0;
  localparam int C_HDR   = 1;
  localparam int C_DATA  = 2;
  localparam int C_CKS   = 3;
  localparam int C_END   = 4;
  localparam int C_PAR   = 5;
  localparam int ST_CKBAD = 6;
endpackage

// File: rtl/evchk_classify.sv
module evchk_classify
  import evchk_pkg::*;
(
  input  logic [31:0] word_i,
  output wkind_e      kind_o,
  output logic        par_bad_o
);
  always_comb begin
    if (!word_i[31])      kind_o = W_DATA;
    else if (!word_i[30]) kind_o = W_HDR;
    else if (word_i[29])  kind_o = W_END;
    else                  kind_o = W_START;
  end

  // even parity over bits 30:0
  assign par_bad_o = ^word_i[30:0];
endmodule

// File: rtl/evchk_counter.sv
module evchk_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int SW = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SW-1:0] MAXV = SW'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    sum;

  assign sum = SW'(cnt_q) + SW'(inc_i);

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_q <= '0;
    else if (sum > MAXV)   cnt_q <= {CNT_W{1'b1}};
    else                   cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  // R11
  monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt_q >= $past(cnt_q));

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == {CNT_W{1'b1}}) && !clr |=> cnt_q == {CNT_W{1'b1}});

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/evchk_parser.sv
module evchk_parser
  import evchk_pkg::*;
#(
  parameter int SAMP_W = 8,
  parameter int BRD_W  = 4,
  parameter int FRM_W  = BRD_W + 2,
  parameter int INC_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [30:0]                 in_low,
  input  wkind_e                      kind,
  input  logic                        par_bad,
  input  logic [SAMP_W-1:0]           cfg_samples,
  input  logic [BRD_W-1:0]            cfg_boards,
  output logic [NCNT-1:0][INC_W-1:0]  inc_o,
  output logic                        done_o,
  output logic [ST_W-1:0]             status_o
);
  localparam logic [INC_W-1:0] ONE = INC_W'(1);

  pstate_e               state_q, st_n;
  logic [FRM_W-1:0]      frames_q, frm_n, frm_inc, exp_frm;
  logic [SAMP_W-1:0]     dcnt_q, dcnt_n, dbase;
  logic [30:0]           xor_q, x_n, xbase;
  logic [ST_W-1:0]       ev_q, ev_n, flg_upd, stat_n;
  logic [NCNT-1:0][INC_W-1:0] inc, inc_q;
  logic                  done_n, open, close, take, cks_bad, tail_cks;
  logic [INC_W-1:0]      tail_short, hdr_short;
  logic [SAMP_W:0]       dnext;

  assign exp_frm  = FRM_W'({cfg_boards, 1'b0});
  assign frm_inc  = (&frames_q) ? frames_q : frames_q + 1'b1;
  assign hdr_short = (exp_frm > frames_q) ? INC_W'(exp_frm - frames_q) : '0;
  assign open     = (state_q != P_IDLE);
  assign tail_short = (state_q == P_DATA) ? INC_W'(cfg_samples - dcnt_q) : '0;
  assign tail_cks = (state_q == P_DATA) || (state_q == P_CKS);
  assign dnext    = {1'b0, dbase} + 1'b1;

  always_comb begin
    inc     = '0;
    st_n    = state_q;
    frm_n   = frames_q;
    dcnt_n  = dcnt_q;
    x_n     = xor_q;
    stat_n  = status_o;
    done_n  = 1'b0;
    close   = 1'b0;
    cks_bad = 1'b0;
    take    = 1'b0;
    xbase   = xor_q;
    dbase   = dcnt_q;
    if (in_valid) begin
      unique case (kind)
        W_START: begin
          if (open) begin
            inc[C_END] = ONE;
            close      = 1'b1;
          end else begin
            st_n = P_HDR;
          end
        end
        W_END: begin
          if (!open) inc[C_START] = ONE;
          close = 1'b1;
        end
        W_HDR: begin
          if (!open) inc[C_START] = ONE;
          inc[C_DATA] = tail_short;
          inc[C_CKS]  = INC_W'(tail_cks);
          frm_n  = frm_inc;
          dcnt_n = '0;
          x_n    = '0;
          st_n   = (cfg_samples == '0) ? P_CKS : P_DATA;
        end
        default: begin
          if (state_q == P_CKS) begin
            cks_bad = (in_low != xor_q);
            st_n    = P_HDR;
          end else if (state_q == P_DATA) begin
            take = 1'b1;
          end else begin
            if (!open) inc[C_START] = ONE;
            inc[C_HDR] = ONE;
            frm_n = frm_inc;
            xbase = '0;
            dbase = '0;
            take  = 1'b1;
          end
        end
      endcase
      if (take) begin
        inc[C_PAR] = INC_W'(par_bad);
        x_n    = xbase ^ in_low;
        dcnt_n = dnext[SAMP_W-1:0];
        st_n   = (dnext >= {1'b0, cfg_samples}) ? P_CKS : P_DATA;
      end
      if (close) begin
        inc[C_DATA] = tail_short;
        inc[C_CKS]  = INC_W'(tail_cks);
        inc[C_HDR]  = hdr_short;
      end
    end
    flg_upd = ev_q | {cks_bad, inc[C_PAR] != '0, inc[C_END] != '0,
                      inc[C_CKS] != '0, inc[C_DATA] != '0,
                      inc[C_HDR] != '0, inc[C_START] != '0};
    ev_n = flg_upd;
    if (close) begin
      done_n = 1'b1;
      stat_n = flg_upd;
      ev_n   = '0;
      frm_n  = '0;
      dcnt_n = '0;
      x_n    = '0;
      st_n   = (kind == W_START) ? P_HDR : P_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= P_IDLE;
      frames_q <= '0;
      dcnt_q   <= '0;
      xor_q    <= '0;
      ev_q     <= '0;
      inc_q    <= '0;
      done_o   <= 1'b0;
      status_o <= '0;
    end else begin
      state_q  <= st_n;
      frames_q <= frm_n;
      dcnt_q   <= dcnt_n;
      xor_q    <= x_n;
      ev_q     <= ev_n;
      inc_q    <= inc;
      done_o   <= done_n;
      status_o <= stat_n;
    end
  end

  assign inc_o = inc_q;

  // R10
  missing_end_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (kind == W_START) && (state_q != P_IDLE)
      |=> done_o && status_o[C_END]);

  // R2
  close_done_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (kind == W_END) |=> done_o);

  // R5
  data_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == P_DATA) |-> ({1'b0, dcnt_q} < {1'b0, cfg_samples}));
endmodule

// File: rtl/evchk_top.sv
module evchk_top
  import evchk_pkg::*;
#(
  parameter int SAMP_W = 8,
  parameter int BRD_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_cnt,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  input  logic [SAMP_W-1:0] cfg_samples,
  input  logic [BRD_W-1:0]  cfg_boards,
  output logic              ev_done,
  output logic [6:0]        ev_status,
  output logic [CNT_W-1:0]  cnt_nostart,
  output logic [CNT_W-1:0]  cnt_nohdr,
  output logic [CNT_W-1:0]  cnt_nodata,
  output logic [CNT_W-1:0]  cnt_nocks,
  output logic [CNT_W-1:0]  cnt_noend,
  output logic [CNT_W-1:0]  cnt_parity
);
  localparam int FRM_W = BRD_W + 2;
  localparam int INC_W = (SAMP_W > FRM_W) ? SAMP_W : FRM_W;

  wkind_e                     kind;
  logic                       par_bad;
  logic [NCNT-1:0][INC_W-1:0] inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt;

  evchk_classify u_cls (
    .word_i    (in_word),
    .kind_o    (kind),
    .par_bad_o (par_bad)
  );

  evchk_parser #(
    .SAMP_W (SAMP_W),
    .BRD_W  (BRD_W),
    .FRM_W  (FRM_W),
    .INC_W  (INC_W)
  ) u_prs (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_low      (in_word[30:0]),
    .kind        (kind),
    .par_bad     (par_bad),
    .cfg_samples (cfg_samples),
    .cfg_boards  (cfg_boards),
    .inc_o       (inc),
    .done_o      (ev_done),
    .status_o    (ev_status)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    evchk_counter #(
      .CNT_W (CNT_W),
      .INC_W (INC_W)
    ) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_cnt),
      .inc_i (inc[i]),
      .cnt_o (cnt[i])
    );
  end

  assign cnt_nostart = cnt[C_START];
  assign cnt_nohdr   = cnt[C_HDR];
  assign cnt_nodata  = cnt[C_DATA];
  assign cnt_nocks   = cnt[C_CKS];
  assign cnt_noend   = cnt[C_END];
  assign cnt_parity  = cnt[C_PAR];
endmodule

// File: tb/sim_evchk_top.sv
module sim_evchk_top;
  localparam int CW = 4;
  localparam logic [31:0] W_SOE = 32'hC000_0000;
  localparam logic [31:0] W_EOE = 32'hE000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_cnt = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [7:0] cfg_samples = 8'd4;
  logic [3:0] cfg_boards = 4'd2;
  logic ev_done;
  logic [6:0] ev_status;
  logic [CW-1:0] c_st, c_hd, c_da, c_ck, c_en, c_pa;

  int n_chk = 0;
  int n_err = 0;
  int n_done = 0;
  logic [6:0] last_st = '0;
  logic [9:0] g = 10'd1;
  logic [7:0] fidx = '0;

  always #2 clk = ~clk;

  evchk_top #(.SAMP_W(8), .BRD_W(4), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .clr_cnt(clr_cnt), .in_valid(in_valid),
    .in_word(in_word), .cfg_samples(cfg_samples), .cfg_boards(cfg_boards),
    .ev_done(ev_done), .ev_status(ev_status),
    .cnt_nostart(c_st), .cnt_nohdr(c_hd), .cnt_nodata(c_da),
    .cnt_nocks(c_ck), .cnt_noend(c_en), .cnt_parity(c_pa)
  );

  always @(negedge clk) begin
    if (ev_done) begin
      n_done  = n_done + 1;
      last_st = ev_status;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_cnt(input string tag, input int s, input int h,
                         input int d, input int c, input int e, input int p);
    chk({tag, " nostart"}, int'(c_st), s);
    chk({tag, " nohdr"},   int'(c_hd), h);
    chk({tag, " nodata"},  int'(c_da), d);
    chk({tag, " nocks"},   int'(c_ck), c);
    chk({tag, " noend"},   int'(c_en), e);
    chk({tag, " parity"},  int'(c_pa), p);
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic fresh();
    @(negedge clk);
    clr_cnt = 1'b1;
    @(negedge clk);
    clr_cnt = 1'b0;
  endtask

  function automatic logic [31:0] mk_data(input logic [9:0] s);
    logic [31:0] w;
    w = {2'b00, s, s ^ 10'h2A5, s + 10'd77};
    w[30] = ^w[29:0];
    return w;
  endfunction

  task automatic frame(input int nd, input bit hdr, input bit cks,
                       input bit badpar, input bit badcks);
    logic [30:0] x;
    logic [31:0] w;
    x = '0;
    fidx = fidx + 1'b1;
    if (hdr) send(32'h8000_0000 | {24'h0, fidx});
    for (int i = 0; i < nd; i++) begin
      w = mk_data(g);
      g = g + 10'd13;
      if (badpar && i == 0) w[30] = ~w[30];
      x = x ^ w[30:0];
      send(w);
    end
    if (cks) send({1'b0, badcks ? (x ^ 31'h1) : x});
  endtask

  task automatic good_frames(input int n);
    for (int i = 0; i < n; i++) frame(4, 1, 1, 0, 0);
  endtask

  task automatic t_reset();
    chk_cnt("R13 reset", 0, 0, 0, 0, 0, 0);
    chk("R13 done low", int'(ev_done), 0);
  endtask

  task automatic t_clean();
    int d0;
    fresh(); d0 = n_done;
    send(W_SOE); good_frames(4); send(W_EOE); settle();
    chk("R2 one done", n_done - d0, 1);
    chk("R2 status clean", int'(last_st), 0);
    chk_cnt("R2 R1 clean", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_parity();
    fresh();
    send(W_SOE); frame(4, 1, 1, 1, 0); good_frames(3); send(W_EOE); settle();
    chk("R3 status", int'(last_st), 7'b010_0000);
    chk_cnt("R3", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_badcks();
    fresh();
    send(W_SOE); good_frames(2); frame(4, 1, 1, 0, 1); good_frames(1);
    send(W_EOE); settle();
    chk("R4 status", int'(last_st), 7'b100_0000);
    chk_cnt("R4", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_early_hdr();
    fresh();
    send(W_SOE); good_frames(1); frame(1, 1, 0, 0, 0); good_frames(2);
    send(W_EOE); settle();
    chk("R5 status", int'(last_st), 7'b000_1100);
    chk_cnt("R5", 0, 0, 3, 1, 0, 0);
  endtask

  task automatic t_no_cks();
    fresh();
    send(W_SOE); frame(4, 1, 0, 0, 0); good_frames(3); send(W_EOE); settle();
    chk("R6 status", int'(last_st), 7'b000_1000);
    chk_cnt("R6", 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_no_hdr();
    fresh();
    send(W_SOE); good_frames(1); frame(4, 0, 1, 0, 0); good_frames(2);
    send(W_EOE); settle();
    chk("R7 status", int'(last_st), 7'b000_0010);
    chk_cnt("R7", 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_short_event();
    fresh();
    send(W_SOE); good_frames(2); send(W_EOE); settle();
    chk("R8 status", int'(last_st), 7'b000_0010);
    chk_cnt("R8", 0, 2, 0, 0, 0, 0);
  endtask

  task automatic t_no_start();
    fresh();
    good_frames(4); send(W_EOE); settle();
    chk("R9 status", int'(last_st), 7'b000_0001);
    chk_cnt("R9", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_no_end();
    int d0;
    logic [6:0] first;
    fresh(); d0 = n_done;
    send(W_SOE); good_frames(4);
    send(W_SOE);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    first = last_st;
    good_frames(4); send(W_EOE); settle();
    chk("R10 first status", int'(first), 7'b001_0000);
    chk("R10 second status", int'(last_st), 0);
    chk("R10 done count", n_done - d0, 2);
    chk_cnt("R10", 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_saturate();
    fresh();
    cfg_samples = 8'd15;
    for (int k = 0; k < 2; k++) begin
      send(W_SOE); send(32'h8000_0001); send(W_EOE);
    end
    settle();
    chk_cnt("R11 sat", 0, 6, 15, 2, 0, 0);
    cfg_samples = 8'd4;
  endtask

  task automatic t_clear();
    fresh();
    @(negedge clk);
    chk_cnt("R12 clear", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_parity();
    t_badcks();
    t_early_hdr();
    t_no_cks();
    t_no_hdr();
    t_short_event();
    t_no_start();
    t_no_end();
    t_saturate();
    t_clear();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule